// File: doc/BRIEF.md
# 64-bit Shift and Rotate Unit

This unit is the shift datapath of a 64-bit processor. It takes a data operand, an amount source and a 4-bit operation code. It returns the operand shifted left logically, shifted right logically, shifted right arithmetically, or rotated right. The operation code also picks where the shift amount comes from:

- a 5-bit immediate (0 to 31);
- the same immediate biased by 32 (32 to 63);
- the low six bits of a register value.

The shifter itself is combinational. Its result is captured in an output register when the input strobe is high, and a valid flag marks the cycle after each capture.

Operation code layout: bits [3:2] select the amount form and bits [1:0] select the shift kind.

| Bits | Value | Meaning |
|---|---|---|
| [3:2] | 0 | immediate form |
| [3:2] | 1 | immediate plus 32 form |
| [3:2] | 2 | register form |
| [3:2] | 3 | unused |
| [1:0] | 0 | logical left shift |
| [1:0] | 1 | logical right shift |
| [1:0] | 2 | arithmetic right shift |
| [1:0] | 3 | rotate right |

Top module: `shrot_unit`

## Requirements
- R1: Codes 0 to 3 (immediate form) shift by `shamt_src[4:0]`, and the upper bits of `shamt_src` have no effect.
- R2: Codes 4 to 7 (immediate plus 32 form) shift by `shamt_src[4:0] + 32`.
- R3: Codes 8 to 11 (register form) shift by `shamt_src[5:0]`, that is, the amount is taken modulo 64.
- R4: Logical left shift (kind 0) moves bits toward bit 63 and fills the vacated low positions with zeros.
- R5: Logical right shift (kind 1) moves bits toward bit 0 and fills the vacated high positions with zeros.
- R6: Arithmetic right shift (kind 2) fills the vacated high positions with copies of operand bit 63.
- R7: Rotate right (kind 3) by n moves the low n operand bits into the top n result positions. A rotate with an effective amount of zero returns the operand unchanged.
- R8: Codes 12 to 15 produce a result of zero.
- R9: When `in_valid` is high at a rising edge, that edge loads `result`. `res_valid` is high after an edge exactly when `in_valid` was high at that edge.
- R10: When `in_valid` is low at a rising edge, `result` keeps its value, whatever the other inputs do.
- R11: Synchronous active-high reset clears `result` and `res_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Captures the current result on this edge |
| op | input | 4 | Amount form in [3:2], shift kind in [1:0] |
| operand | input | 64 | Data to shift or rotate |
| shamt_src | input | 64 | Immediate amount in [4:0], or register amount in [5:0] |
| result | output | 64 | Registered shift or rotate result |
| res_valid | output | 1 | High for the cycle after a captured strobe |

## Verification
Each result is due one rising edge after the strobe that carries its inputs. The bench drives inputs on the falling edge, lets one rising edge pass, and reads `result` and `res_valid` on the next falling edge. One further falling edge later, it confirms that `res_valid` has dropped and that `result` has held while the inputs change with the strobe low. Reset is checked the same way: `rst` is held across one rising edge, and the outputs are read on the following falling edge.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {
    KIND_SLL = 2'd0,
    KIND_SRL = 2'd1,
    KIND_SRA = 2'd2,
    KIND_ROR = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    FORM_IMM  = 2'd0,
    FORM_HI   = 2'd1,
    FORM_REG  = 2'd2,
    FORM_NONE = 2'd3
  } form_e;
endpackage

// File: rtl/shrot_amount.sv
module shrot_amount
  import shrot_pkg::*;
#(
  parameter int AMT_W = 6
) (
  input  form_e            form,
  input  logic [AMT_W-1:0] amt_low,
  output logic [AMT_W-1:0] amt,
  output logic             legal
);
  always_comb begin
    amt   = '0;
    legal = 1'b1;
    case (form)
      FORM_IMM: amt = {1'b0, amt_low[AMT_W-2:0]};
      FORM_HI:  amt = {1'b1, amt_low[AMT_W-2:0]};
      FORM_REG: amt = amt_low;
      default:  legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  kind_e             kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] res
);
  logic              do_left;
  logic              do_rot;
  logic              fill;
  logic [DATA_W-1:0] flipped;
  logic [DATA_W-1:0] pre;
  logic [DATA_W-1:0] post_flip;
  logic [DATA_W-1:0] stg [AMT_W+1];

  assign do_left = (kind == KIND_SLL);
  assign do_rot  = (kind == KIND_ROR);
  assign fill    = (kind == KIND_SRA) & data[DATA_W-1];

  // A left shift is a right shift of the bit-reversed operand.
  for (genvar b = 0; b < DATA_W; b++) begin : g_flip_in
    assign flipped[b] = data[DATA_W-1-b];
  end
  assign pre    = do_left ? flipped : data;
  assign stg[0] = pre;

  // Logarithmic right network; each stage either wraps or fills.
  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int SH = 1 << i;
    logic [SH-1:0] top_bits;
    assign top_bits   = do_rot ? stg[i][SH-1:0] : {SH{fill}};
    assign stg[i+1]   = amt[i] ? {top_bits, stg[i][DATA_W-1:SH]} : stg[i];
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_flip_out
    assign post_flip[b] = stg[AMT_W][DATA_W-1-b];
  end
  assign res = do_left ? post_flip : stg[AMT_W];
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] shamt_src,
  output logic [DATA_W-1:0] result,
  output logic              res_valid
);
  form_e             form;
  kind_e             kind;
  logic [AMT_W-1:0]  amt;
  logic              legal;
  logic [DATA_W-1:0] core_res;
  logic [DATA_W-1:0] next_res;
  logic              unused_hi;

  assign form      = form_e'(op[3:2]);
  assign kind      = kind_e'(op[1:0]);
  assign unused_hi = ^shamt_src[DATA_W-1:AMT_W];

  shrot_amount #(.AMT_W(AMT_W)) i_amount (
    .form    (form),
    .amt_low (shamt_src[AMT_W-1:0]),
    .amt     (amt),
    .legal   (legal)
  );

  shrot_core #(.DATA_W(DATA_W)) i_core (
    .kind (kind),
    .amt  (amt),
    .data (operand),
    .res  (core_res)
  );

  assign next_res = legal ? core_res : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[3:2] == 2'd3) |=> (result == '0));
  p_rot_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd11 && shamt_src[AMT_W-1:0] == '0)
      |=> (result == $past(operand)));
  p_sra_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd6 && shamt_src[AMT_W-2:0] == '1)
      |=> (result == {DATA_W{$past(operand[DATA_W-1])}}));
endmodule

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
module test_shrot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] operand = '0;
  logic [63:0] shamt_src = '0;
  logic [63:0] result;
  logic        res_valid;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shrot_unit i_shrot_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .operand(operand), .shamt_src(shamt_src),
    .result(result), .res_valid(res_valid)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] s;
    logic [63:0] e;
  } vec_t;

  localparam logic [63:0] PA = 64'h8000_0000_0000_0001;
  localparam logic [63:0] PB = 64'h0123_4567_89AB_CDEF;

  localparam vec_t VEC [17] = '{
    '{8'd4,  4'd0,  PA, 64'd4, 64'h0000_0000_0000_0010},                     // R4
    '{8'd1,  4'd0,  PA, 64'hFFFF_FFFF_FFFF_FFE1, 64'h0000_0000_0000_0002},   // R1
    '{8'd5,  4'd1,  PA, 64'd1, 64'h4000_0000_0000_0000},                     // R5
    '{8'd6,  4'd2,  PA, 64'd4, 64'hF800_0000_0000_0000},                     // R6
    '{8'd7,  4'd3,  PA, 64'd1, 64'hC000_0000_0000_0000},                     // R7
    '{8'd2,  4'd4,  PA, 64'd0, 64'h0000_0001_0000_0000},                     // R2
    '{8'd2,  4'd5,  PA, 64'd31, 64'h0000_0000_0000_0001},                    // R2
    '{8'd6,  4'd6,  PA, 64'd31, 64'hFFFF_FFFF_FFFF_FFFF},                    // R6
    '{8'd2,  4'd7,  PB, 64'd0, 64'h89AB_CDEF_0123_4567},                     // R2
    '{8'd3,  4'd8,  64'd1, 64'h47, 64'h0000_0000_0000_0080},                 // R3
    '{8'd3,  4'd9,  PA, 64'h3F, 64'h0000_0000_0000_0001},                    // R3
    '{8'd3,  4'd10, PA, 64'd0, PA},                                          // R3
    '{8'd7,  4'd11, PB, 64'h40, PB},                                         // R7
    '{8'd7,  4'd11, PB, 64'd4, 64'hF012_3456_789A_BCDE},                     // R7
    '{8'd6,  4'd2,  64'h7FF0_0000_0000_0000, 64'd8, 64'h007F_F000_0000_0000},// R6
    '{8'd8,  4'd12, PA, 64'd1, 64'd0},                                       // R8
    '{8'd8,  4'd15, PB, 64'd5, 64'd0}                                        // R8
  };

  task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] o, input logic [63:0] a, input logic [63:0] s);
    @(negedge clk);
    op = o; operand = a; shamt_src = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [63:0] held;
    repeat (2) @(negedge clk);
    check(11, result, 64'd0);            // R11 reset value
    check(11, {63'd0, res_valid}, 64'd0); // R11
    rst = 1'b0;

    for (int k = 0; k < 17; k++) begin
      strobe(VEC[k].op, VEC[k].a, VEC[k].s);
      check(int'(VEC[k].req), result, VEC[k].e);
      check(9, {63'd0, res_valid}, 64'd1); // R9 flag after strobe
    end

    // R10: inputs move with strobe low; result must hold
    held = result;
    op = 4'd0; operand = PB; shamt_src = 64'd3;
    @(negedge clk);
    check(10, result, held);
    check(9, {63'd0, res_valid}, 64'd0); // R9 flag drops
    @(negedge clk);
    check(10, result, held);

    // R1: upper amount bits ignored in immediate right shift
    strobe(4'd1, PB, 64'hABCD_0000_0000_0040);
    check(1, result, PB);

    // R11: reset mid-run
    strobe(4'd3, PB, 64'd8);
    check(7, result, 64'hEF01_2345_6789_ABCD); // R7
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check(11, result, 64'd0);
    check(11, {63'd0, res_valid}, 64'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule